// File: doc/BRIEF.md
# Serial EEPROM Burst Reader

This block is the master side of a four-wire serial EEPROM link: chip select, serial clock, data toward the memory and data back from it. A single request names a start address and a word count. The block then reads that many consecutive 16-bit words, one full READ command frame per word. Each word is presented on an output port with its index inside the burst, and a done pulse marks the end of the burst.

Every frame has the same shape. Chip select rises and is held for one setup clock period. The start bit and the read opcode follow, then the address, most significant bit first. Next come seventeen sampled bits: the memory's leading zero and then the data word, MSB first. Chip select then drops for one more clock period. The serial clock comes from a divider that sets the high and low phase lengths in system clock cycles. Address width is a parameter that takes the value 6 or 8.

Top module: `sebr_burst_reader`

## Requirements
- R1: After reset and whenever idle, `busy_o`, `done_o`, `word_valid_o`, `ee_cs_o`, `ee_sk_o` and `ee_di_o` are all low.
- R2: A request with a non-zero count, sampled while idle, raises `busy_o` and `ee_cs_o` in the next cycle.
- R3: After its setup period, every frame sends the start bit and read opcode as the bit sequence 1,1,0. It then sends the ADDR_W address bits MSB first, where ADDR_W is 6 or 8.
- R4: The memory drives a 0 on the first rising SK edge after the last address bit and one data bit, MSB first, on each later rising edge. The block samples `ee_do_i` in the last system cycle of each SK high phase. It takes 17 samples, discards the leading 0 and returns the remaining 16 bits as `word_data_o`.
- R5: Word i of a burst (i = 0 … count−1) is read from address (start + i) mod 2^ADDR_W and is reported with `word_idx_o` = i, in ascending order.
- R6: `ee_cs_o` rises while SK is low. Exactly one SK rising edge, with DI low, occurs before the start bit.
- R7: After each word's last sample, `ee_cs_o` is low across exactly one SK rising edge. This happens before the next frame and also before done.
- R8: While busy, SK is high for exactly HI_CYC cycles and low for exactly LO_CYC cycles. HI_CYC·CLK_PERIOD_NS must be at least 750 and LO_CYC·CLK_PERIOD_NS at least 250.
- R9: `ee_cs_o` and `ee_di_o` change only on the edge where SK falls or while SK is low.
- R10: A request with count 0 starts no frame and leaves `busy_o` low. `done_o` pulses in the cycle after the request.
- R11: `done_o` is a single-cycle pulse, one per request. It falls in the cycle after the final high phase of the last frame's closing period, and `busy_o` is already low in that cycle.
- R12: A request made while busy is ignored; the running burst and its results are unchanged, and no second burst follows.
- R13: `word_valid_o` is a single-cycle pulse per word. It falls in the cycle after that word's final sample, with `ee_cs_o` and `ee_sk_o` both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Burst request, sampled while idle |
| start_addr_i | input | ADDR_W | First word address |
| word_cnt_i | input | ADDR_W+1 | Number of words to read |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| word_valid_o | output | 1 | One-cycle pulse, word outputs valid |
| word_idx_o | output | ADDR_W+1 | Index of the word within the burst |
| word_data_o | output | 16 | Word read from the memory |
| ee_cs_o | output | 1 | Memory chip select |
| ee_sk_o | output | 1 | Memory serial clock |
| ee_di_o | output | 1 | Serial data toward the memory |
| ee_do_i | input | 1 | Serial data from the memory |

## Verification
The response to a request arrives one clock later. For a non-zero count, `busy_o` and chip select are high in that cycle. For a zero count, `done_o` is high instead. Each `word_valid_o` arrives one cycle after the word's last SK high cycle. `done_o` arrives one cycle after the closing period's high phase, so the bench also checks the previous sampled SK and CS levels. The bench drives on falling clock edges and samples every output on falling edges. All waveform measurements (phase lengths, rising edges counted per setup and gap, decoded opcode) come from that same falling-edge monitor. The bench therefore always reads registered values in the middle of a cycle.

// File: rtl/sebr_pkg.sv
package sebr_pkg;

   // Which part of a command frame the serial clock period belongs to.
   typedef enum logic [2:0] {
      SL_IDLE,
      SL_SETUP,
      SL_CMD,
      SL_ADDR,
      SL_READ,
      SL_TAIL
   } slot_e;

   // Start bit plus read opcode, stored so that bit 0 is sent first: 1,1,0.
   localparam int PRE_LEN = 3;
   localparam logic [PRE_LEN-1:0] PRE_SEND_LSB_FIRST = 3'b011;

endpackage

// File: rtl/sebr_sk_gen.sv
// Serial clock divider. A bit period is a low phase followed by a high phase.
module sebr_sk_gen #(
   parameter int HI_CYC = 75,
   parameter int LO_CYC = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sk_o,
   output logic slot_end_o
);

   generate
      if (HI_CYC == 1 && LO_CYC == 1) begin : g_toggle
         logic sk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sk_q <= 1'b0;
            else if (!run_i) sk_q <= 1'b0;
            else             sk_q <= ~sk_q;
         end
         assign sk_o       = sk_q;
         assign slot_end_o = run_i && sk_q;
      end else begin : g_count
         localparam int MAXC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
         localparam int CW   = $clog2(MAXC + 1);
         localparam logic [CW-1:0] HI_LAST = CW'(HI_CYC - 1);
         localparam logic [CW-1:0] LO_LAST = CW'(LO_CYC - 1);
         logic          ph_q;
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph_q  <= 1'b0;
               cnt_q <= '0;
            end else if (!run_i) begin
               ph_q  <= 1'b0;
               cnt_q <= '0;
            end else if (!ph_q) begin
               if (cnt_q == LO_LAST) begin
                  ph_q  <= 1'b1;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               if (cnt_q == HI_LAST) begin
                  ph_q  <= 1'b0;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
         assign sk_o       = ph_q;
         assign slot_end_o = run_i && ph_q && (cnt_q == HI_LAST);
      end
   endgenerate

endmodule

// File: rtl/sebr_frame_seq.sv
// Steps through the bit periods of one read frame and drives CS and DI.
module sebr_frame_seq
   import sebr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              more_i,
   input  logic              slot_end_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              run_o,
   output logic              cs_o,
   output logic              di_o,
   output logic              sample_o,
   output logic              last_sample_o,
   output logic              frame_end_o
);

   localparam int RD_BITS = DATA_W + 1;
   localparam int BC_W    = $clog2(RD_BITS + ADDR_W + PRE_LEN + 1);
   localparam logic [BC_W-1:0] PRE_LAST  = BC_W'(PRE_LEN - 1);
   localparam logic [BC_W-1:0] ADDR_LAST = BC_W'(ADDR_W - 1);
   localparam logic [BC_W-1:0] RD_LAST   = BC_W'(RD_BITS - 1);

   slot_e           kind_q, kind_n;
   logic [BC_W-1:0] bcnt_q, bcnt_n;
   logic            cs_q, di_q, cs_n, di_n;
   logic [PRE_LEN-1:0] pre_sh;
   logic [ADDR_W-1:0]  addr_sh;

   always_comb begin
      kind_n = kind_q;
      bcnt_n = bcnt_q;
      unique case (kind_q)
         SL_IDLE: begin
            if (start_i) begin
               kind_n = SL_SETUP;
               bcnt_n = '0;
            end
         end
         SL_SETUP: begin
            if (slot_end_i) begin
               kind_n = SL_CMD;
               bcnt_n = '0;
            end
         end
         SL_CMD: begin
            if (slot_end_i) begin
               if (bcnt_q == PRE_LAST) begin
                  kind_n = SL_ADDR;
                  bcnt_n = '0;
               end else begin
                  bcnt_n = bcnt_q + 1'b1;
               end
            end
         end
         SL_ADDR: begin
            if (slot_end_i) begin
               if (bcnt_q == ADDR_LAST) begin
                  kind_n = SL_READ;
                  bcnt_n = '0;
               end else begin
                  bcnt_n = bcnt_q + 1'b1;
               end
            end
         end
         SL_READ: begin
            if (slot_end_i) begin
               if (bcnt_q == RD_LAST) begin
                  kind_n = SL_TAIL;
                  bcnt_n = '0;
               end else begin
                  bcnt_n = bcnt_q + 1'b1;
               end
            end
         end
         SL_TAIL: begin
            if (slot_end_i) begin
               kind_n = more_i ? SL_SETUP : SL_IDLE;
               bcnt_n = '0;
            end
         end
         default: begin
            kind_n = SL_IDLE;
            bcnt_n = '0;
         end
      endcase
   end

   // Output bit for the period about to begin; registered so that it moves
   // together with the falling serial clock.
   always_comb begin
      pre_sh  = PRE_SEND_LSB_FIRST >> bcnt_n;
      addr_sh = addr_i >> (ADDR_LAST - bcnt_n);
      cs_n    = (kind_n == SL_SETUP) || (kind_n == SL_CMD) ||
                (kind_n == SL_ADDR)  || (kind_n == SL_READ);
      unique case (kind_n)
         SL_CMD:  di_n = pre_sh[0];
         SL_ADDR: di_n = addr_sh[0];
         default: di_n = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= SL_IDLE;
         bcnt_q <= '0;
         cs_q   <= 1'b0;
         di_q   <= 1'b0;
      end else begin
         kind_q <= kind_n;
         bcnt_q <= bcnt_n;
         cs_q   <= cs_n;
         di_q   <= di_n;
      end
   end

   assign run_o         = (kind_q != SL_IDLE);
   assign cs_o          = cs_q;
   assign di_o          = di_q;
   assign sample_o      = slot_end_i && (kind_q == SL_READ);
   assign last_sample_o = sample_o && (bcnt_q == RD_LAST);
   assign frame_end_o   = slot_end_i && (kind_q == SL_TAIL);

endmodule

// File: rtl/sebr_rx_shift.sv
// Receive shifter. It holds W-1 bits, so the leading zero of a 17-bit read
// falls off the top and the next-value output carries the full data word.
module sebr_rx_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_i,
   input  logic         bit_i,
   output logic [W-1:0] word_nxt_o
);

   logic [W-2:0] sr_q;

   assign word_nxt_o = {sr_q, bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (shift_i) sr_q <= word_nxt_o[W-2:0];
   end

endmodule

// File: rtl/sebr_burst_reader.sv
// Burst reader: one read frame per word, consecutive addresses.
module sebr_burst_reader
   import sebr_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_NS = 10,
   parameter int HI_CYC        = 75,
   parameter int LO_CYC        = 25,
   localparam int CNT_W        = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   input  logic [CNT_W-1:0]  word_cnt_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              word_valid_o,
   output logic [CNT_W-1:0]  word_idx_o,
   output logic [DATA_W-1:0] word_data_o,
   output logic              ee_cs_o,
   output logic              ee_sk_o,
   output logic              ee_di_o,
   input  logic              ee_do_i
);

   logic              run_q, done_q, wv_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  idx_q, rem_q, widx_q;
   logic [DATA_W-1:0] data_q;

   logic req_ok, cnt_zero, seq_start, seq_run, slot_end;
   logic sample, last_sample, frame_end;
   logic [DATA_W-1:0] rx_word;

   assign req_ok    = req_i && !run_q;
   assign cnt_zero  = (word_cnt_i == '0);
   assign seq_start = req_ok && !cnt_zero;

   sebr_sk_gen #(
      .HI_CYC (HI_CYC),
      .LO_CYC (LO_CYC)
   ) u_sk (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (seq_run),
      .sk_o       (ee_sk_o),
      .slot_end_o (slot_end)
   );

   sebr_frame_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (seq_start),
      .more_i        (rem_q != '0),
      .slot_end_i    (slot_end),
      .addr_i        (addr_q),
      .run_o         (seq_run),
      .cs_o          (ee_cs_o),
      .di_o          (ee_di_o),
      .sample_o      (sample),
      .last_sample_o (last_sample),
      .frame_end_o   (frame_end)
   );

   sebr_rx_shift #(
      .W (DATA_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_i    (sample),
      .bit_i      (ee_do_i),
      .word_nxt_o (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         wv_q   <= 1'b0;
         addr_q <= '0;
         idx_q  <= '0;
         rem_q  <= '0;
         widx_q <= '0;
         data_q <= '0;
      end else begin
         done_q <= 1'b0;
         wv_q   <= 1'b0;
         if (req_ok) begin
            if (cnt_zero) begin
               done_q <= 1'b1;
            end else begin
               run_q  <= 1'b1;
               addr_q <= start_addr_i;
               idx_q  <= '0;
               rem_q  <= word_cnt_i - 1'b1;
            end
         end
         if (frame_end) begin
            if (rem_q == '0) begin
               run_q  <= 1'b0;
               done_q <= 1'b1;
            end else begin
               rem_q  <= rem_q - 1'b1;
               addr_q <= addr_q + 1'b1;
               idx_q  <= idx_q + 1'b1;
            end
         end
         if (last_sample) begin
            wv_q   <= 1'b1;
            data_q <= rx_word;
            widx_q <= idx_q;
         end
      end
   end

   assign busy_o       = run_q;
   assign done_o       = done_q;
   assign word_valid_o = wv_q;
   assign word_idx_o   = widx_q;
   assign word_data_o  = data_q;

endmodule

// File: rtl/sebr_burst_reader_chk.sv
module sebr_burst_reader_chk #(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 16,
   parameter int CLK_PERIOD_NS = 10,
   parameter int HI_CYC        = 75,
   parameter int LO_CYC        = 25
) (
   input logic clk,
   input logic rst_n,
   input logic busy_o,
   input logic done_o,
   input logic word_valid_o,
   input logic ee_cs_o,
   input logic ee_sk_o,
   input logic ee_di_o
);

   initial begin
      a_r3_addr_width: assert (ADDR_W == 6 || ADDR_W == 8)
         else $error("address width must be 6 or 8");
      a_r4_data_width: assert (DATA_W == 16)
         else $error("data width must be 16");
      a_r8_hi_time: assert (HI_CYC * CLK_PERIOD_NS >= 750)
         else $error("serial clock high phase too short");
      a_r8_lo_time: assert (LO_CYC * CLK_PERIOD_NS >= 250)
         else $error("serial clock low phase too short");
   end

   logic [15:0] hi_len, lo_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         lo_len <= '0;
      end else begin
         hi_len <= ee_sk_o ? hi_len + 1'b1 : '0;
         lo_len <= (busy_o && !ee_sk_o) ? lo_len + 1'b1 : '0;
      end
   end

   a_r8_hi_len: assert property (@(posedge clk) disable iff (!rst_n)
      hi_len <= 16'(HI_CYC));
   a_r8_lo_len: assert property (@(posedge clk) disable iff (!rst_n)
      lo_len <= 16'(LO_CYC));
   a_r9_cs_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ee_cs_o) |-> !ee_sk_o);
   a_r9_di_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ee_di_o) |-> !ee_sk_o);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!ee_cs_o && !ee_sk_o && !ee_di_o && !word_valid_o));
   a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !ee_cs_o));
   a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r13_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |=> !word_valid_o);
   a_r13_valid_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> (busy_o && !ee_cs_o && !ee_sk_o));

endmodule

bind sebr_burst_reader sebr_burst_reader_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .HI_CYC        (HI_CYC),
   .LO_CYC        (LO_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .word_valid_o (word_valid_o),
   .ee_cs_o      (ee_cs_o),
   .ee_sk_o      (ee_sk_o),
   .ee_di_o      (ee_di_o)
);

// File: tb/sebr_burst_reader_test.sv
`timescale 1ns/1ps
module sebr_burst_reader_test;

   localparam int AW    = 6;
   localparam int CW    = AW + 1;
   localparam int HI    = 3;
   localparam int LO    = 1;
   localparam int CLKNS = 250;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic [AW-1:0] start_i = '0;
   logic [CW-1:0] cnt_i = '0;
   logic busy, done, wvalid, cs, sk, di;
   logic [CW-1:0] widx;
   logic [15:0] wdata;
   logic sdo_r = 1'b1;

   always #5 clk = ~clk;

   sebr_burst_reader #(
      .ADDR_W (AW), .DATA_W (16), .CLK_PERIOD_NS (CLKNS),
      .HI_CYC (HI), .LO_CYC (LO)
   ) uut (
      .clk (clk), .rst_n (rst_n), .req_i (req), .start_addr_i (start_i),
      .word_cnt_i (cnt_i), .busy_o (busy), .done_o (done),
      .word_valid_o (wvalid), .word_idx_o (widx), .word_data_o (wdata),
      .ee_cs_o (cs), .ee_sk_o (sk), .ee_di_o (di), .ee_do_i (sdo_r)
   );

   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Burst context and memory contents
   logic [15:0]   seed16 = 16'h1234;
   logic [AW-1:0] b_start = '0;
   int            b_count = 0;

   function automatic logic [15:0] mem_val(input logic [AW-1:0] a);
      logic [31:0] p;
      p = 32'(a) * 32'd40503;
      return p[15:0] ^ seed16;
   endfunction

   // Falling-edge monitor: memory model and waveform measurement
   logic prev_sk = 1'b0, prev_cs = 1'b0;
   int lo_run = 0, hi_run = 0, edge_n = 0;
   int setup_edges = 0, gap_edges = 0, frames = 0;
   int width_err = 0, setup_err = 0, gap_err = 0, op_err = 0;
   int exp_idx = 0, done_seen = 0;
   logic [1:0]    op = '0;
   logic [AW-1:0] maddr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (cs && !prev_cs) begin
            if (frames > 0 && gap_edges != 1) gap_err++;
            gap_edges = 0; setup_edges = 0; edge_n = 0; frames++;
         end
         if (sk && !prev_sk) begin
            if (lo_run != LO) width_err++;
            lo_run = 0;
            if (cs) begin
               if (edge_n == 0) begin
                  if (di) begin
                     if (setup_edges != 1) setup_err++;
                     edge_n = 1; op = '0; maddr = '0;
                  end else begin
                     setup_edges++;
                  end
               end else begin
                  edge_n++;
                  if (edge_n <= 3) op = {op[0], di};
                  else if (edge_n <= 3 + AW) maddr = {maddr[AW-2:0], di};
                  if (edge_n == 4 + AW) begin
                     if (op != 2'b10) op_err++;
                     sdo_r = (op == 2'b10) ? 1'b0 : 1'b1;
                  end else if (edge_n >= 5 + AW && edge_n <= 20 + AW) begin
                     logic [15:0] t;
                     t = mem_val(maddr) >> (15 - (edge_n - 5 - AW));
                     sdo_r = (op == 2'b10) ? t[0] : 1'b1;
                  end else begin
                     sdo_r = 1'b1;
                  end
               end
            end else begin
               gap_edges++;
            end
         end
         if (!sk && prev_sk) begin
            if (hi_run != HI) width_err++;
            hi_run = 0;
         end
         if (!cs) sdo_r = 1'b1;
         if (sk) hi_run++;
         else if (busy) lo_run++;
         else lo_run = 0;

         if (wvalid) begin
            logic [AW-1:0] ea;
            ea = b_start + AW'(exp_idx);
            chk(!cs && !sk && prev_sk && prev_cs, "R13", "valid timing", int'(cs), 0);
            chk(widx == CW'(exp_idx), "R5", "word index", int'(widx), exp_idx);
            chk(wdata == mem_val(ea), "R4", "word data", int'(wdata), int'(mem_val(ea)));
            exp_idx++;
         end
         if (done) begin
            done_seen++;
            if (b_count != 0) begin
               chk(!busy && !cs && prev_sk && !prev_cs, "R11", "done timing",
                   int'(busy), 0);
               chk(gap_edges == 1, "R7", "final gap edges", gap_edges, 1);
            end
         end
         prev_sk = sk;
         prev_cs = cs;
      end
   end

   task automatic run_burst(input logic [AW-1:0] st, input int cnt, input bit inject);
      int limit;
      bit got;
      b_start = st; b_count = cnt;
      seed16 = 16'($urandom);
      exp_idx = 0; done_seen = 0; frames = 0;
      width_err = 0; setup_err = 0; gap_err = 0; op_err = 0;
      @(negedge clk);
      req = 1'b1; start_i = st; cnt_i = CW'(cnt);
      @(negedge clk);
      req = 1'b0;
      if (cnt == 0)
         chk(done && !busy && !cs, "R10", "zero count done", int'(done), 1);
      else
         chk(busy && cs && !done, "R2", "busy and cs after request", int'(busy), 1);
      if (inject) begin
         repeat (40) @(negedge clk);
         req = 1'b1; start_i = ~st; cnt_i = CW'(5);
         @(negedge clk);
         req = 1'b0;
      end
      limit = cnt * 40 * (HI + LO) + 100;
      got = 1'b0;
      for (int i = 0; i < limit; i++) begin
         @(posedge clk);
         if (done_seen > 0) begin got = 1'b1; break; end
      end
      chk(got, "R11", "burst finished in time", int'(got), 1);
      repeat (20) @(negedge clk);
      chk(done_seen == 1, "R11", "done pulses", done_seen, 1);
      chk(exp_idx == cnt, "R5", "words returned", exp_idx, cnt);
      chk(frames == cnt, "R12", "frames started", frames, cnt);
      chk(!busy && !cs, "R12", "idle after burst", int'(busy), 0);
      if (cnt > 0) begin
         chk(op_err == 0, "R3", "opcode errors", op_err, 0);
         chk(setup_err == 0, "R6", "setup errors", setup_err, 0);
         chk(gap_err == 0, "R7", "gap errors", gap_err, 0);
         chk(width_err == 0, "R8", "clock phase errors", width_err, 0);
      end
   endtask

   initial begin
      int sd;
      sd = $urandom(32'd20240611);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !wvalid && !cs && !sk && !di, "R1", "idle outputs",
          int'({busy, done, wvalid, cs, sk, di}), 0);
      run_burst(AW'(0), 1, 1'b0);
      run_burst(AW'(62), 3, 1'b0);        // address wrap, R5
      run_burst(AW'(5), 0, 1'b0);         // zero count, R10
      run_burst(AW'(0), 1 << AW, 1'b0);   // whole array
      run_burst(AW'(10), 4, 1'b1);        // request while busy, R12
      for (int n = 0; n < 12; n++) begin
         run_burst(AW'($urandom % (1 << AW)), 1 + int'($urandom % 12), n[0]);
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule